// File: doc/BRIEF.md
# Descriptor-Driven Loop Transfer Engine

This block is one channel of a copy engine that runs a single transfer descriptor. A descriptor sets up two nested loops. The inner loop moves a fixed number of bytes as a string of beats; each beat reads from a source address and then writes the same data to a destination address. The outer loop repeats the inner loop for an iteration count. After every access the address is stepped by a signed offset. When the outer count runs out, a signed end adjustment is added to each address. The engine can then either stop and raise done, or follow a link to fetch and run a further descriptor from memory.

A descriptor reaches the engine in one of two ways: all eight words at once through a parallel load port, or fetched word by word over a small memory read port. Runs are started in one of two ways. A software trigger (the descriptor's own start flag, or a start pulse) runs every outer iteration back to back. A peripheral request line, while the request enable is set, runs one inner loop per request. Data moves over a plain request/acknowledge bus that carries an access size code.

Top module: `dle_engine`

## Requirements
- R1: After reset, busy, done, req_en, irq_half, irq_major, bus_req and df_req are all low.
- R2: A descriptor presented on ld_valid/ld_desc is taken only while the engine is idle; a load offered while busy is ignored and the running transfer continues unchanged.
- R3: The descriptor is eight 32-bit words, word i at ld_desc[32*i+:32]. The words are, in order: source address; source offset [31:16], source size [10:8] and destination size [2:0]; inner byte count; source end adjustment; destination address; destination offset [31:16] and current count field [15:0]; destination end adjustment or link address; begin count field [31:16] and control bits [7:0]. In a count field, bit 15 clear makes bits [14:0] the count; bit 15 set makes only bits [8:0] the count.
- R4: Each beat reads the source (bus_we=0, bus_size = source size) and then writes the data it read to the destination (bus_we=1, bus_size = destination size). After its access, each address is stepped by its sign-extended offset. Size codes 0, 1, 2, 4 and 5 mean 1, 2, 4, 16 and 32 bytes. The inner loop ends after the beat that leaves the remaining byte count (counted in source units) at or below one unit, so it always makes at least one beat.
- R5: Control bit 0 set in a loaded descriptor, or a pulse on sw_start while a descriptor is held, runs all remaining outer iterations back to back.
- R6: While req_en is high, a periph_req seen in idle runs exactly one inner loop, after which the engine goes idle again.
- R7: When the count reaches zero, the end adjustments are added to both addresses and the count is reloaded from the begin count. Without a link, done rises and busy falls. done clears when the next run starts, and a restarted run uses the adjusted addresses.
- R8: With control bit 6 set, irq_half pulses for one cycle when the decremented count equals half the begin count (rounded down) and is not zero.
- R9: With control bit 7 set, irq_major pulses for one cycle at the end of the outer loop, while no data access is pending.
- R10: With control bit 4 set, the end of the outer loop fetches eight words from the link address (word i from address + 4i) and loads them as a descriptor. If the new descriptor's bit 0 is set, it starts at once.
- R11: req_en_set sets req_en. With control bit 5 set, req_en is cleared at the end of the outer loop, after which requests have no effect.
- R12: bus_req and df_req hold their address until acknowledged, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Parallel descriptor load strobe |
| ld_desc | input | 256 | Eight descriptor words, word 0 lowest |
| sw_start | input | 1 | Software start pulse |
| periph_req | input | 1 | Peripheral request line |
| req_en_set | input | 1 | Sets the request enable |
| req_en | output | 1 | Request enable state |
| df_req | output | 1 | Descriptor fetch read request |
| df_addr | output | 32 | Descriptor fetch byte address |
| df_ack | input | 1 | Fetch acknowledge, data valid |
| df_rdata | input | 32 | Fetched word |
| bus_req | output | 1 | Data access request |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | 32 | Data access byte address |
| bus_size | output | 3 | Access size code |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Data access acknowledge |
| bus_rdata | input | 32 | Read data |
| busy | output | 1 | Engine not idle |
| done | output | 1 | Outer loop finished without a link |
| irq_half | output | 1 | Half-way pulse |
| irq_major | output | 1 | Outer loop complete pulse |

## Verification
The bench builds the engine with its default 32-bit data width and the fixed eight-word descriptor, so the whole 15-bit count range is available. It uses this to run 513 outer iterations, which crosses the boundary of the 9-bit field and needs the extended high bits. It also checks that the link-enable bit folds the count back to nine bits. Wait states come from an acknowledge that drops one cycle in four. This tests that requests are held and that a link fetch interleaves correctly with data beats.

// File: rtl/dle_pkg.sv
`timescale 1ns/1ps
package dle_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 8;
  localparam int ITER_W     = 15;

  typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_WRITE, ST_MINOR, ST_FETCH} dle_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] nbytes;
    logic [WORD_W-1:0] slast;
    logic [WORD_W-1:0] dlast;
    logic [15:0]       soff;
    logic [15:0]       doff;
    logic [2:0]        ssize;
    logic [2:0]        dsize;
    logic              link_sg;
    logic              drop_req;
    logic              irq_half_en;
    logic              irq_major_en;
  } dle_cfg_t;

  // bytes moved per access for a size code
  function automatic logic [5:0] unit_bytes(input logic [2:0] code);
    case (code)
      3'd1:    unit_bytes = 6'd2;
      3'd2:    unit_bytes = 6'd4;
      3'd4:    unit_bytes = 6'd16;
      3'd5:    unit_bytes = 6'd32;
      default: unit_bytes = 6'd1;
    endcase
  endfunction

  // bit 15 set: 9-bit count; clear: 15-bit count
  function automatic logic [ITER_W-1:0] iter_decode(input logic [15:0] f);
    iter_decode = f[15] ? {6'd0, f[8:0]} : f[14:0];
  endfunction
endpackage

// File: rtl/dle_fetch.sv
`timescale 1ns/1ps
module dle_fetch #(
  parameter int WORDS = 8,
  parameter int W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [W-1:0]     base,
  output logic             df_req,
  output logic [W-1:0]     df_addr,
  input  logic             df_ack,
  input  logic [W-1:0]     df_rdata,
  output logic             fin,
  output logic [WORDS*W-1:0] desc
);
  localparam int IDX_W = $clog2(WORDS);

  logic             active_q, active_d, fin_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [W-1:0]     base_q, base_d;
  logic [WORDS*W-1:0] words_q, words_d;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    base_d   = base_q;
    words_d  = words_q;
    fin_d    = 1'b0;
    if (go && !active_q) begin
      active_d = 1'b1;
      idx_d    = '0;
      base_d   = base;
    end else if (active_q && df_ack) begin
      words_d[idx_q*W +: W] = df_rdata;
      if (idx_q == IDX_W'(WORDS-1)) begin
        active_d = 1'b0;
        fin_d    = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      fin      <= 1'b0;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      fin      <= fin_d;
      idx_q    <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    base_q  <= base_d;
    words_q <= words_d;
  end

  assign df_req  = active_q;
  assign df_addr = base_q + W'(idx_q) * W'(W/8);
  assign desc    = words_q;
endmodule

// File: rtl/dle_iter.sv
`timescale 1ns/1ps
module dle_iter #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] citer_in,
  input  logic [CW-1:0] biter_in,
  input  logic          dec,
  output logic          last,
  output logic          half_next
);
  logic [CW-1:0] citer_q, citer_d, biter_q, biter_d;

  always_comb begin
    citer_d = citer_q;
    biter_d = biter_q;
    if (load) begin
      citer_d = citer_in;
      biter_d = biter_in;
    end else if (dec) begin
      citer_d = last ? biter_q : citer_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      citer_q <= '0;
      biter_q <= '0;
    end else begin
      citer_q <= citer_d;
      biter_q <= biter_d;
    end
  end

  // a zero count is run as a single iteration
  assign last      = (citer_q <= CW'(1));
  assign half_next = !last && ((citer_q - CW'(1)) == (biter_q >> 1));
endmodule

// File: rtl/dle_engine.sv
`timescale 1ns/1ps
module dle_engine
  import dle_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld_valid,
  input  logic [DESC_WORDS*WORD_W-1:0] ld_desc,
  input  logic                         sw_start,
  input  logic                         periph_req,
  input  logic                         req_en_set,
  output logic                         req_en,
  output logic                         df_req,
  output logic [WORD_W-1:0]            df_addr,
  input  logic                         df_ack,
  input  logic [WORD_W-1:0]            df_rdata,
  output logic                         bus_req,
  output logic                         bus_we,
  output logic [WORD_W-1:0]            bus_addr,
  output logic [2:0]                   bus_size,
  output logic [DATA_W-1:0]            bus_wdata,
  input  logic                         bus_ack,
  input  logic [DATA_W-1:0]            bus_rdata,
  output logic                         busy,
  output logic                         done,
  output logic                         irq_half,
  output logic                         irq_major
);
  localparam int DW_BITS = DESC_WORDS * WORD_W;

  dle_state_e          state_q, state_d;
  dle_cfg_t            cfg_q, cfg_d;
  logic [WORD_W-1:0]   saddr_q, saddr_d, daddr_q, daddr_d, remain_q, remain_d, unit;
  logic [DATA_W-1:0]   data_q, data_d;
  logic                armed_q, armed_d, startf_q, startf_d, mode_sw_q, mode_sw_d;
  logic                done_d, req_en_d, irq_half_d, irq_major_d;
  logic                load, iter_dec, last, half_next, fetch_go, fetch_fin;
  logic [DW_BITS-1:0]  fetch_desc, desc_in;
  logic [WORD_W-1:0]   w [DESC_WORDS];
  logic                dle_unused;

  assign desc_in = (state_q == ST_FETCH) ? fetch_desc : ld_desc;
  assign load    = (state_q == ST_IDLE && ld_valid) || fetch_fin;
  assign unit    = WORD_W'(unit_bytes(cfg_q.ssize));

  always_comb begin
    for (int i = 0; i < DESC_WORDS; i++) w[i] = desc_in[i*WORD_W +: WORD_W];
  end

  // reserved and status-only descriptor bits carry no function here
  assign dle_unused = ^{w[1][15:11], w[1][7:3], w[7][15:8], w[7][3:1]};

  dle_fetch #(.WORDS(DESC_WORDS), .W(WORD_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(fetch_go), .base(cfg_q.dlast),
    .df_req(df_req), .df_addr(df_addr), .df_ack(df_ack), .df_rdata(df_rdata),
    .fin(fetch_fin), .desc(fetch_desc));

  dle_iter #(.CW(ITER_W)) u_iter (
    .clk(clk), .rst_n(rst_n), .load(load),
    .citer_in(iter_decode(w[5][15:0])), .biter_in(iter_decode(w[7][31:16])),
    .dec(iter_dec), .last(last), .half_next(half_next));

  always_comb begin
    state_d     = state_q;
    cfg_d       = cfg_q;
    saddr_d     = saddr_q;
    daddr_d     = daddr_q;
    remain_d    = remain_q;
    data_d      = data_q;
    armed_d     = armed_q;
    startf_d    = startf_q;
    mode_sw_d   = mode_sw_q;
    done_d      = done;
    req_en_d    = req_en | req_en_set;
    irq_half_d  = 1'b0;
    irq_major_d = 1'b0;
    iter_dec    = 1'b0;
    fetch_go    = 1'b0;
    if (load) begin
      saddr_d            = w[0];
      cfg_d.soff         = w[1][31:16];
      cfg_d.ssize        = w[1][10:8];
      cfg_d.dsize        = w[1][2:0];
      cfg_d.nbytes       = w[2];
      cfg_d.slast        = w[3];
      daddr_d            = w[4];
      cfg_d.doff         = w[5][31:16];
      cfg_d.dlast        = w[6];
      cfg_d.link_sg      = w[7][4];
      cfg_d.drop_req     = w[7][5];
      cfg_d.irq_half_en  = w[7][6];
      cfg_d.irq_major_en = w[7][7];
      startf_d           = w[7][0];
      armed_d            = 1'b1;
      done_d             = 1'b0;
    end
    case (state_q)
      ST_IDLE: begin
        if (!ld_valid && armed_q && (sw_start || startf_q || (req_en && periph_req))) begin
          state_d   = ST_READ;
          mode_sw_d = sw_start || startf_q;
          startf_d  = 1'b0;
          done_d    = 1'b0;
          remain_d  = cfg_q.nbytes;
        end
      end
      ST_READ: begin
        if (bus_ack) begin
          data_d  = bus_rdata;
          saddr_d = saddr_q + {{16{cfg_q.soff[15]}}, cfg_q.soff};
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (bus_ack) begin
          daddr_d = daddr_q + {{16{cfg_q.doff[15]}}, cfg_q.doff};
          if (remain_q <= unit) begin
            state_d = ST_MINOR;
          end else begin
            remain_d = remain_q - unit;
            state_d  = ST_READ;
          end
        end
      end
      ST_MINOR: begin
        iter_dec   = 1'b1;
        irq_half_d = cfg_q.irq_half_en && half_next;
        if (last) begin
          saddr_d     = saddr_q + cfg_q.slast;
          daddr_d     = daddr_q + cfg_q.dlast;
          irq_major_d = cfg_q.irq_major_en;
          if (cfg_q.drop_req) req_en_d = 1'b0;
          if (cfg_q.link_sg) begin
            fetch_go = 1'b1;
            state_d  = ST_FETCH;
          end else begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end else if (mode_sw_q) begin
          remain_d = cfg_q.nbytes;
          state_d  = ST_READ;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_FETCH: if (fetch_fin) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      armed_q   <= 1'b0;
      startf_q  <= 1'b0;
      mode_sw_q <= 1'b0;
      done      <= 1'b0;
      req_en    <= 1'b0;
      irq_half  <= 1'b0;
      irq_major <= 1'b0;
    end else begin
      state_q   <= state_d;
      armed_q   <= armed_d;
      startf_q  <= startf_d;
      mode_sw_q <= mode_sw_d;
      done      <= done_d;
      req_en    <= req_en_d;
      irq_half  <= irq_half_d;
      irq_major <= irq_major_d;
    end
  end

  always_ff @(posedge clk) begin
    cfg_q    <= cfg_d;
    saddr_q  <= saddr_d;
    daddr_q  <= daddr_d;
    remain_q <= remain_d;
    data_q   <= data_d;
  end

  assign busy      = (state_q != ST_IDLE);
  assign bus_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign bus_we    = (state_q == ST_WRITE);
  assign bus_addr  = bus_we ? daddr_q : saddr_q;
  assign bus_size  = bus_we ? cfg_q.dsize : cfg_q.ssize;
  assign bus_wdata = data_q;
endmodule

// File: rtl/dle_engine_chk.sv
`timescale 1ns/1ps
module dle_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        bus_req,
  input logic        bus_ack,
  input logic        bus_we,
  input logic [31:0] bus_addr,
  input logic        df_req,
  input logic        df_ack,
  input logic [31:0] df_addr,
  input logic        irq_half,
  input logic        irq_major
);
  p_bus_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we));

  p_fetch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    df_req && !df_ack |=> df_req && $stable(df_addr));

  p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(df_req && bus_req));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_half_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_half && irq_major));

  p_major_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_major |-> !bus_req);
endmodule

bind dle_engine dle_engine_chk u_chk (.*);

// File: tb/dle_engine_test.sv
`timescale 1ns/1ps
module dle_engine_test;
  logic clk = 1'b0;
  logic rst_n;
  logic ld_valid, sw_start, periph_req, req_en_set, req_en;
  logic [255:0] ld_desc;
  logic df_req, df_ack, bus_req, bus_we, bus_ack, busy, done, irq_half, irq_major;
  logic [31:0] df_addr, df_rdata, bus_addr, bus_wdata, bus_rdata;
  logic [2:0] bus_size;

  always #5 clk = ~clk;

  dle_engine uut (.*);

  int checks = 0, errors = 0, n_half = 0, n_major = 0, n_fetch = 0, n_bus = 0;
  bit finished = 0;
  logic [67:0] exp_q[$];
  string tag_q[$];
  logic [31:0] m_src, m_dst, fexp;
  logic [31:0] dmem [16];
  logic [1:0] cyc = 2'd0;
  logic ack_en = 1'b1;

  localparam logic [7:0] C_START = 8'h01, C_SG = 8'h10, C_DREQ = 8'h20,
                         C_HALF = 8'h40, C_MAJ = 8'h80;

  function automatic logic [31:0] rdv(input logic [31:0] a);
    return (a * 32'd3) ^ 32'h5A5A_0000;
  endfunction

  function automatic int bunit(input logic [2:0] c);
    if (c == 3'd1) return 2;
    if (c == 3'd2) return 4;
    if (c == 3'd4) return 16;
    if (c == 3'd5) return 32;
    return 1;
  endfunction

  function automatic logic [255:0] mkd(input logic [31:0] src, input logic [15:0] so,
      input logic [2:0] ss, input logic [2:0] ds, input logic [31:0] nb, input logic [31:0] sl,
      input logic [31:0] dst, input logic [15:0] doo, input logic [15:0] cit,
      input logic [31:0] dl, input logic [15:0] bt, input logic [7:0] ctl);
    return {{bt, 8'h00, ctl}, dl, {doo, cit}, dst, sl, nb, {so, 5'b0, ss, 5'b0, ds}, src};
  endfunction

  task automatic check(input bit ok, input string req, input logic [67:0] act, input logic [67:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // bus acknowledge drops one cycle in four
  always @(posedge clk) begin
    cyc    <= cyc + 2'd1;
    ack_en <= (cyc != 2'd2);
  end
  assign bus_ack   = bus_req & ack_en;
  assign bus_rdata = rdv(bus_addr);
  assign df_ack    = df_req & ack_en;
  assign df_rdata  = dmem[df_addr[5:2]];

  // monitor: pops expected accesses as the engine makes them
  always @(negedge clk) begin
    if (rst_n) begin
      if (df_req && bus_req) check(1'b0, "R12 overlap", 68'd1, 68'd0);
      if (bus_req && bus_ack) begin
        logic [67:0] got;
        got = {bus_we, bus_size, bus_addr, bus_we ? bus_wdata : bus_rdata};
        n_bus++;
        if (exp_q.size() == 0) check(1'b0, "R12 unexpected access", got, 68'd0);
        else begin
          logic [67:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(got == e, t, got, e);
        end
      end
      if (df_req && df_ack) begin
        n_fetch++;
        check(df_addr == fexp, "R10 fetch address", {36'd0, df_addr}, {36'd0, fexp});
        fexp = fexp + 32'd4;
      end
      if (irq_half) n_half++;
      if (irq_major) n_major++;
    end
  end

  task automatic push_minor(input logic [15:0] so, input logic [15:0] doo, input logic [2:0] ss,
                            input logic [2:0] ds, input int nb, input string tag);
    int rem;
    logic [31:0] d;
    rem = nb;
    forever begin
      d = rdv(m_src);
      exp_q.push_back({1'b0, ss, m_src, d}); tag_q.push_back(tag);
      exp_q.push_back({1'b1, ds, m_dst, d}); tag_q.push_back(tag);
      m_src = m_src + {{16{so[15]}}, so};
      m_dst = m_dst + {{16{doo[15]}}, doo};
      if (rem <= bunit(ss)) break;
      rem = rem - bunit(ss);
    end
  endtask

  task automatic push_major(input int n, input logic [15:0] so, input logic [15:0] doo,
      input logic [2:0] ss, input logic [2:0] ds, input int nb, input logic [31:0] sl,
      input logic [31:0] dl, input string tag);
    for (int i = 0; i < n; i++) push_minor(so, doo, ss, ds, nb, tag);
    m_src = m_src + sl;
    m_dst = m_dst + dl;
  endtask

  task automatic load(input logic [255:0] d);
    @(negedge clk); ld_valid = 1'b1; ld_desc = d;
    @(negedge clk); ld_valid = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); periph_req = 1'b1;
    @(negedge clk); periph_req = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (exp_q.size() != 0 || busy);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int mj, nb0;
    logic [255:0] nxt;
    rst_n = 1'b0; ld_valid = 1'b0; ld_desc = '0; sw_start = 1'b0;
    periph_req = 1'b0; req_en_set = 1'b0; fexp = 32'h1000;
    for (int i = 0; i < 16; i++) dmem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({busy, done, req_en} == 3'b000, "R1 status", {65'd0, busy, done, req_en}, 68'd0);
    check({irq_half, irq_major} == 2'b00, "R1 irq", {66'd0, irq_half, irq_major}, 68'd0);
    check({bus_req, df_req} == 2'b00, "R1 requests", {66'd0, bus_req, df_req}, 68'd0);

    // R5 software start, R7 adjustments, R8 half, R9 major, R2 busy load
    m_src = 32'h100; m_dst = 32'h800;
    push_major(3, 16'd4, 16'd4, 3'd2, 3'd2, 8, 32'hFFFF_FFE8, 32'h40, "R5 sw run");
    load(mkd(32'h100, 16'd4, 3'd2, 3'd2, 32'd8, 32'hFFFF_FFE8, 32'h800, 16'd4, 16'd3,
             32'h40, 16'd3, C_HALF | C_MAJ));
    check(done == 1'b0 && busy == 1'b0, "R2 load idle", {66'd0, done, busy}, 68'd0);
    kick();
    repeat (4) @(negedge clk);
    // R2: this load carries a start bit and foreign addresses; it must be dropped
    ld_valid = 1'b1;
    ld_desc  = mkd(32'hDEAD_0000, 16'd4, 3'd2, 3'd2, 32'd4, 32'd0, 32'hBEEF_0000, 16'd4,
                   16'd1, 32'd0, 16'd1, C_START);
    @(negedge clk); ld_valid = 1'b0;
    drain();
    check(done == 1'b1, "R7 done", {67'd0, done}, 68'd1);
    check(n_half == 1, "R8 half count", 68'(n_half), 68'd1);
    check(n_major == 1, "R9 major count", 68'(n_major), 68'd1);
    // R7 restart uses adjusted addresses (src back to 0x100, dst at 0x858)
    push_major(3, 16'd4, 16'd4, 3'd2, 3'd2, 8, 32'hFFFF_FFE8, 32'h40, "R7 rerun");
    kick();
    @(negedge clk);
    check(done == 1'b0, "R7 done clears", {67'd0, done}, 68'd0);
    drain();
    check(n_half == 2 && n_major == 2, "R8 R9 rerun", 68'(n_half * 16 + n_major), 68'd34);

    // R4 fixed source, negative destination step, mixed sizes, auto start
    m_src = 32'h40; m_dst = 32'h2000;
    push_major(1, 16'd0, 16'hFFFF, 3'd0, 3'd1, 3, 32'd0, 32'd0, "R4 fifo");
    load(mkd(32'h40, 16'd0, 3'd0, 3'd1, 32'd3, 32'd0, 32'h2000, 16'hFFFF, 16'd1,
             32'd0, 16'd1, C_START));
    drain();
    // R4 16-byte and 32-byte units
    m_src = 32'h400; m_dst = 32'h3000;
    push_major(1, 16'd16, 16'd16, 3'd4, 3'd4, 32, 32'd0, 32'd0, "R4 size16");
    load(mkd(32'h400, 16'd16, 3'd4, 3'd4, 32'd32, 32'd0, 32'h3000, 16'd16, 16'd1,
             32'd0, 16'd1, C_START));
    drain();
    m_src = 32'h480; m_dst = 32'h3100;
    push_major(1, 16'd32, 16'd32, 3'd5, 3'd5, 32, 32'd0, 32'd0, "R4 size32");
    load(mkd(32'h480, 16'd32, 3'd5, 3'd5, 32'd32, 32'd0, 32'h3100, 16'd32, 16'd1,
             32'd0, 16'd1, C_START));
    drain();

    // R3 count field: link bit clear gives 15 bits (513), set gives 9 bits (2)
    m_src = 32'h10; m_dst = 32'h4000;
    push_major(513, 16'd1, 16'd1, 3'd0, 3'd0, 1, 32'd0, 32'd0, "R3 wide count");
    load(mkd(32'h10, 16'd1, 3'd0, 3'd0, 32'd1, 32'd0, 32'h4000, 16'd1, 16'h0201,
             32'd0, 16'h0201, C_START));
    drain();
    check(done == 1'b1, "R3 wide done", {67'd0, done}, 68'd1);
    m_src = 32'h20; m_dst = 32'h5000;
    push_major(2, 16'd1, 16'd1, 3'd0, 3'd0, 1, 32'd0, 32'd0, "R3 linked count");
    load(mkd(32'h20, 16'd1, 3'd0, 3'd0, 32'd1, 32'd0, 32'h5000, 16'd1, 16'h8202,
             32'd0, 16'h8202, C_START));
    drain();

    // R6 one inner loop per request, R11 request enable dropped at the end
    mj = n_major;
    m_src = 32'h500; m_dst = 32'h600;
    load(mkd(32'h500, 16'd4, 3'd2, 3'd2, 32'd4, 32'd0, 32'h600, 16'd4, 16'd2,
             32'd0, 16'd2, C_DREQ | C_MAJ));
    @(negedge clk); req_en_set = 1'b1;
    @(negedge clk); req_en_set = 1'b0;
    check(req_en == 1'b1, "R11 set", {67'd0, req_en}, 68'd1);
    push_minor(16'd4, 16'd4, 3'd2, 3'd2, 4, "R6 first request");
    pulse_req();
    drain();
    check(busy == 1'b0 && done == 1'b0, "R6 one loop only", {66'd0, busy, done}, 68'd0);
    push_major(1, 16'd4, 16'd4, 3'd2, 3'd2, 4, 32'd0, 32'd0, "R6 second request");
    pulse_req();
    drain();
    check(done == 1'b1, "R7 hw done", {67'd0, done}, 68'd1);
    check(req_en == 1'b0, "R11 cleared", {67'd0, req_en}, 68'd0);
    check(n_major == mj + 1, "R9 hw major", 68'(n_major), 68'(mj + 1));
    nb0 = n_bus;
    pulse_req();
    repeat (10) @(negedge clk);
    check(n_bus == nb0 && busy == 1'b0, "R11 request ignored", 68'(n_bus), 68'(nb0));

    // R10 link: run one loop, fetch the next descriptor at 0x1000, which starts itself
    mj = n_major;
    nxt = mkd(32'h300, 16'd4, 3'd2, 3'd2, 32'd4, 32'd0, 32'h900, 16'd4, 16'd2,
              32'd0, 16'd2, C_START | C_MAJ);
    for (int i = 0; i < 8; i++) dmem[i] = nxt[i*32 +: 32];
    m_src = 32'h200; m_dst = 32'h700;
    push_minor(16'd4, 16'd4, 3'd2, 3'd2, 4, "R10 first");
    m_src = 32'h300; m_dst = 32'h900;
    push_major(2, 16'd4, 16'd4, 3'd2, 3'd2, 4, 32'd0, 32'd0, "R10 linked");
    load(mkd(32'h200, 16'd4, 3'd2, 3'd2, 32'd4, 32'd0, 32'h700, 16'd4, 16'd1,
             32'h1000, 16'd1, C_START | C_SG));
    drain();
    check(n_fetch == 8, "R10 fetch count", 68'(n_fetch), 68'd8);
    check(done == 1'b1 && n_major == mj + 1, "R10 linked done", {67'd0, done}, 68'd1);

    finished = 1;
    summary();
    $finish;
  end
endmodule